// File: doc/BRIEF.md
# Factory Bad-Block Table Scanner

This engine builds the invalid-block table for a NAND array. It runs once per `start`. It walks the erase blocks in ascending order from block 0. For each block it fetches the byte at the start of the spare area of the block's first page, and of the second page when needed. It then writes a one-bit verdict for the block into a table port. A block counts as invalid when either inspected byte differs from the erased value FFh.

Page fetches go through a request/acknowledge port. The engine presents a row address and a column and holds them until the memory side returns one data byte with an acknowledge. The NAND bus cycles sit behind that port. The engine counts the invalid blocks it finds. It raises a warning level when that count passes the number of bad blocks the array may legally carry. It pulses `done` once the last verdict is written.

Top module: `nbs_scanner`

## Requirements
- R1: During and right after reset, `rd_req`, `tbl_we`, `done` and `busy` are low, and `bad_count` and `warn` are 0.
- R2: After an accepted `start`, blocks are fetched and written in strictly ascending order 0 .. NUM_BLOCKS-1. Each block gets exactly one table write, with `tbl_idx` equal to the block number. Fetches of a block come before its write, and only one of fetch, write or done is active in any cycle.
- R3: A fetch request sets `rd_row` = block × PAGES_PER_BLOCK + page, with page 0 or 1, and `rd_col` = SPARE_COL (2048, the first spare byte). `rd_req` and `rd_row` stay unchanged until the cycle in which `rd_ack` is high.
- R4: When the page-0 marker byte is not FFh, the block is written with `tbl_bad` = 1 and no page-1 fetch is issued for that block.
- R5: When the page-0 marker is FFh, page 1 is fetched. The block is written bad when the page-1 marker is not FFh and good when it is FFh.
- R6: `bad_count` is cleared by an accepted `start` and rises by one in the cycle after each table write with `tbl_bad` = 1.
- R7: `warn` is high exactly when `bad_count` exceeds BAD_LIMIT (default 40). It is 0 after an accepted `start`.
- R8: `done` is high for exactly one cycle, in the cycle right after the write of the last block. `busy` is high from the cycle after an accepted `start` through the `done` cycle.
- R9: `start` asserted while `busy` is high has no effect: the walk, the table writes and `bad_count` continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (accepted only when idle) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_count | output | CNT_W | Number of invalid blocks found |
| warn | output | 1 | Invalid count exceeds BAD_LIMIT |
| rd_req | output | 1 | Page fetch request |
| rd_row | output | ROW_W | Page row address of the fetch |
| rd_col | output | COL_W | Column of the fetch |
| rd_ack | input | 1 | Fetch acknowledge, qualifies `rd_data` |
| rd_data | input | 8 | Byte returned by the fetch |
| tbl_we | output | 1 | Table write strobe |
| tbl_idx | output | BLK_W | Block index being written |
| tbl_bad | output | 1 | Verdict: 1 means invalid |

## Verification
The final table write and the crossing of the warning threshold can fall together. In that case `bad_count` reaches BAD_LIMIT+1 and `warn` rises in the same cycle as `done`. The bench sets this up with a pattern whose last block is marked on page 0 while earlier blocks bring the count exactly to the limit. It judges that `warn` is still low during the last write and that the count and the warning are both correct when `done` is observed. A second overlap, a `start` pulse landing mid-walk while a fetch is in flight, is judged by the index sequence and the final count.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WRITE,
        ST_DONE
    } scan_state_e;

    // Outcome of one accepted fetch
    typedef struct packed {
        logic bad_now;      // returned marker byte is not erased
        logic need_second;  // page 0 clean: page 1 must be fetched
        logic finish;       // verdict for this block is settled
    } judge_t;

    function automatic logic marker_is_bad(input logic [7:0] b);
        return b != ERASED_BYTE;
    endfunction

endpackage

// File: rtl/nbs_walker.sv
module nbs_walker #(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    localparam int BLK_W = $clog2(NUM_BLOCKS),
    localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_W = BLK_W + PG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance_page,
    input  logic             advance_block,
    output logic [BLK_W-1:0] blk,
    output logic             page_sel,
    output logic [ROW_W-1:0] row,
    output logic             last_block
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            blk      <= '0;
            page_sel <= 1'b0;
        end else if (advance_block) begin
            blk      <= blk + BLK_W'(1);
            page_sel <= 1'b0;
        end else if (advance_page) begin
            page_sel <= 1'b1;
        end
    end

    assign last_block = (blk == BLK_W'(NUM_BLOCKS - 1));

    generate
        if ((1 << PG_W) == PAGES_PER_BLOCK) begin : g_pow2_row
            assign row = {blk, PG_W'(page_sel)};
        end else begin : g_mul_row
            assign row = ROW_W'(blk) * ROW_W'(PAGES_PER_BLOCK) + ROW_W'(page_sel);
        end
    endgenerate

endmodule

// File: rtl/nbs_judge.sv
module nbs_judge
    import nbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       take,
    input  logic [7:0] data,
    input  logic       page_sel,
    output judge_t     judge,
    output logic       verdict_bad
);

    always_comb begin
        judge.bad_now     = marker_is_bad(data);
        judge.need_second = take && !judge.bad_now && !page_sel;
        judge.finish      = take && (judge.bad_now || page_sel);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            verdict_bad <= 1'b0;
        end else if (judge.finish) begin
            verdict_bad <= judge.bad_now;
        end
    end

endmodule

// File: rtl/nbs_tally.sv
module nbs_tally #(
    parameter int NUM_BLOCKS = 2048,
    parameter int BAD_LIMIT  = 40,
    localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bump,
    output logic [CNT_W-1:0] count,
    output logic             warn
);

    logic [CNT_W-1:0] count_n;

    always_comb begin
        count_n = count;
        if (bump && count != CNT_W'(NUM_BLOCKS))
            count_n = count + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
            warn  <= 1'b0;
        end else begin
            count <= count_n;
            warn  <= (32'(count_n) > BAD_LIMIT);
        end
    end

endmodule

// File: rtl/nbs_scanner.sv
module nbs_scanner
    import nbs_pkg::*;
#(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int PAGE_BYTES      = 2112,
    parameter int SPARE_COL       = 2048,
    parameter int BAD_LIMIT       = 40,
    localparam int BLK_W = $clog2(NUM_BLOCKS),
    localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_W = BLK_W + PG_W,
    localparam int COL_W = $clog2(PAGE_BYTES),
    localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] bad_count,
    output logic             warn,
    output logic             rd_req,
    output logic [ROW_W-1:0] rd_row,
    output logic [COL_W-1:0] rd_col,
    input  logic             rd_ack,
    input  logic [7:0]       rd_data,
    output logic             tbl_we,
    output logic [BLK_W-1:0] tbl_idx,
    output logic             tbl_bad
);

    scan_state_e      state, state_n;
    logic             launch, take;
    logic [BLK_W-1:0] blk;
    logic             page_sel, last_block, verdict_bad;
    judge_t           judge;

    assign launch = (state == ST_IDLE) && start;
    assign take   = (state == ST_FETCH) && rd_ack;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start) state_n = ST_FETCH;
            ST_FETCH: if (judge.finish) state_n = ST_WRITE;
            ST_WRITE: state_n = last_block ? ST_DONE : ST_FETCH;
            ST_DONE:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    nbs_walker #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .PAGES_PER_BLOCK (PAGES_PER_BLOCK)
    ) u_walker (
        .clk           (clk),
        .rst           (rst),
        .clear         (launch),
        .advance_page  (judge.need_second),
        .advance_block ((state == ST_WRITE) && !last_block),
        .blk           (blk),
        .page_sel      (page_sel),
        .row           (rd_row),
        .last_block    (last_block)
    );

    nbs_judge u_judge (
        .clk         (clk),
        .rst         (rst),
        .clear       (launch),
        .take        (take),
        .data        (rd_data),
        .page_sel    (page_sel),
        .judge       (judge),
        .verdict_bad (verdict_bad)
    );

    nbs_tally #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BAD_LIMIT  (BAD_LIMIT)
    ) u_tally (
        .clk   (clk),
        .rst   (rst),
        .clear (launch),
        .bump  ((state == ST_WRITE) && verdict_bad),
        .count (bad_count),
        .warn  (warn)
    );

    assign rd_req  = (state == ST_FETCH);
    assign rd_col  = COL_W'(SPARE_COL);
    assign tbl_we  = (state == ST_WRITE);
    assign tbl_idx = blk;
    assign tbl_bad = verdict_bad;
    assign done    = (state == ST_DONE);
    assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/nbs_scanner_chk.sv
module nbs_scanner_chk #(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int PAGE_BYTES      = 2112,
    parameter int BAD_LIMIT       = 40,
    localparam int BLK_W = $clog2(NUM_BLOCKS),
    localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_W = BLK_W + PG_W,
    localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] bad_count,
    input logic             warn,
    input logic             rd_req,
    input logic [ROW_W-1:0] rd_row,
    input logic             rd_ack,
    input logic             tbl_we,
    input logic [BLK_W-1:0] tbl_idx,
    input logic             tbl_bad
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rd_req && !tbl_we && !done));

    assert_one_activity_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_req, tbl_we, done}));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_row)));

    assert_page_range_R3: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_row[PG_W-1:0] <= PG_W'(1)));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        (tbl_we && tbl_bad) |=> (bad_count == $past(bad_count) + CNT_W'(1)));

    assert_warn_level_R7: assert property (@(posedge clk) disable iff (rst)
        warn == (32'(bad_count) > BAD_LIMIT));

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(tbl_we) && $past(tbl_idx) == BLK_W'(NUM_BLOCKS - 1)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind nbs_scanner nbs_scanner_chk #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .PAGE_BYTES      (PAGE_BYTES),
    .BAD_LIMIT       (BAD_LIMIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .bad_count (bad_count),
    .warn      (warn),
    .rd_req    (rd_req),
    .rd_row    (rd_row),
    .rd_ack    (rd_ack),
    .tbl_we    (tbl_we),
    .tbl_idx   (tbl_idx),
    .tbl_bad   (tbl_bad)
);

// File: tb/tb_nbs_scanner.sv
module tb_nbs_scanner;

    localparam int NB    = 8;
    localparam int PPB   = 64;
    localparam int PB    = 2112;
    localparam int SPARE = 2048;
    localparam int LIM   = 2;
    localparam int BLK_W = $clog2(NB);
    localparam int PG_W  = $clog2(PPB);
    localparam int ROW_W = BLK_W + PG_W;
    localparam int COL_W = $clog2(PB);
    localparam int CNT_W = $clog2(NB + 1);
    localparam int NV    = 5;

    // per scenario: page-0 bad mask, page-1 bad mask, start poke mid-walk
    localparam logic [NB-1:0] P0 [NV] = '{8'h0F, 8'h00, 8'h01, 8'h00, 8'h80};
    localparam logic [NB-1:0] P1 [NV] = '{8'hFF, 8'h00, 8'h80, 8'hA5, 8'h06};
    localparam bit            PK [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, rd_ack = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic busy, done, warn, rd_req, tbl_we, tbl_bad;
    logic [CNT_W-1:0] bad_count;
    logic [ROW_W-1:0] rd_row;
    logic [COL_W-1:0] rd_col;
    logic [BLK_W-1:0] tbl_idx;

    int total = 0, fails = 0;

    always #4 clk = ~clk;

    nbs_scanner #(
        .NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .PAGE_BYTES(PB),
        .SPARE_COL(SPARE), .BAD_LIMIT(LIM)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .bad_count(bad_count), .warn(warn), .rd_req(rd_req), .rd_row(rd_row),
        .rd_col(rd_col), .rd_ack(rd_ack), .rd_data(rd_data), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_bad(tbl_bad)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] marker(input int b, input logic bad);
        if (!bad) return 8'hFF;
        case (b % 3)
            0:       return 8'h00;
            1:       return 8'hFE;
            default: return 8'h7F;
        endcase
    endfunction

    task automatic run_scan(input int v);
        logic [NB-1:0] p0, p1;
        bit seen1 [NB];
        int writes = 0, we_cyc = -10, served = 0, waitc = 0, expcnt = 0, run = 0;
        bit got_done = 0, poked = 0, pend = 0;
        logic [ROW_W-1:0] prev_row = '0;
        p0 = P0[v];
        p1 = P1[v];
        for (int b = 0; b < NB; b++) begin
            seen1[b] = 0;
            expcnt += int'(p0[b] | p1[b]);
        end
        @(negedge clk);
        start = 1'b1;
        for (int cyc = 0; cyc < 4000 && !got_done; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            if (PK[v] && writes == 3 && !poked) begin
                start = 1'b1;   // R9: must be ignored while busy
                poked = 1;
            end
            if (tbl_we) begin
                check(int'(tbl_idx) == writes, "R2", "table index", int'(tbl_idx), writes);
                check(tbl_bad == (p0[writes] | p1[writes]), p0[writes] ? "R4" : "R5",
                      "verdict", int'(tbl_bad), int'(p0[writes] | p1[writes]));
                check(seen1[writes] == !p0[writes], p0[writes] ? "R4" : "R5",
                      "page-1 fetch issued", int'(seen1[writes]), int'(!p0[writes]));
                check(int'(bad_count) == run, "R6", "count before write", int'(bad_count), run);
                check(warn == (run > LIM), "R7", "warn before write", int'(warn), int'(run > LIM));
                run += int'(p0[writes] | p1[writes]);
                writes++;
                we_cyc = cyc;
            end
            if (done) begin
                check(writes == NB, "R8", "writes at done", writes, NB);
                check(cyc == we_cyc + 1, "R8", "done delay", cyc - we_cyc, 1);
                check(int'(bad_count) == expcnt, "R6", "count at done", int'(bad_count), expcnt);
                check(warn == (expcnt > LIM), "R7", "warn at done", int'(warn), int'(expcnt > LIM));
                got_done = 1;
            end
            if (rd_req && pend)
                check(rd_row == prev_row, "R3", "row held", int'(rd_row), int'(prev_row));
            pend = 0;
            if (rd_ack) begin
                rd_ack = 1'b0;
                waitc = served % 3;
            end else if (rd_req) begin
                int rb, pg;
                rb = int'(rd_row[ROW_W-1:PG_W]);
                pg = int'(rd_row[PG_W-1:0]);
                if (waitc == 0) begin
                    check(int'(rd_col) == SPARE, "R3", "column", int'(rd_col), SPARE);
                    check(rb == writes, "R2", "fetch block", rb, writes);
                    check(pg <= 1, "R3", "page index", pg, 1);
                    if (pg == 1) seen1[rb] = 1;
                    rd_data = marker(rb, (pg == 0) ? p0[rb] : p1[rb]);
                    rd_ack = 1'b1;
                    served++;
                end else begin
                    waitc--;
                    pend = 1;
                    prev_row = rd_row;
                end
            end
        end
        check(got_done, "R8", "done observed", int'(got_done), 1);
        if (PK[v])
            check(int'(bad_count) == expcnt && writes == NB, "R9", "start while busy",
                  int'(bad_count), expcnt);
        @(negedge clk);
        check(!done && !busy, "R8", "idle after done", int'({done, busy}), 0);
        check(int'(bad_count) == expcnt, "R6", "count held", int'(bad_count), expcnt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL R8 watchdog expired: actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!rd_req && !tbl_we && !done && !busy, "R1", "outputs in reset",
              int'({rd_req, tbl_we, done, busy}), 0);
        check(bad_count == '0 && !warn, "R1", "count in reset", int'(bad_count), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !rd_req, "R1", "idle after reset", int'({busy, rd_req}), 0);

        for (int v = 0; v < NV; v++) run_scan(v);

        // reset in the middle of a walk returns everything to the reset state
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(busy && rd_req, "R2", "fetch pending", int'({busy, rd_req}), 3);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !rd_req && !tbl_we && !done, "R1", "mid-walk reset",
              int'({busy, rd_req, tbl_we, done}), 0);
        check(bad_count == '0 && !warn, "R1", "count after reset", int'(bad_count), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, fails);
        $finish;
    end

endmodule